// File: doc/BRIEF.md
# Page-Mode DRAM Array Controller

This block sits between a processor-side word port and a small behavioural DRAM array. The array is a square grid of supercells, 4 rows by 4 columns of 8 bits by default. Each request on the valid/ready port is a word read or a word write. The controller turns it into a row strobe and a column strobe on a narrow multiplexed address bus. The row index is driven during the row strobe and the column index during the column strobe.

A row strobe copies the whole selected row into an internal row buffer, and that row then stays open. Later accesses to the open row issue only a column strobe. Writes change the buffer only. The buffer is copied back into the array when the row is closed, either to open another row or to make way for a refresh. A deadline counter schedules row refreshes in rotation. Once the deadline expires, the refresh wins over any waiting request.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset, req_ready_o is high and rsp_valid_o, ras_o and cas_o are low.
- R2: The request address is split with bits [3:2] as the row and bits [1:0] as the column. A read returns the 8-bit value most recently written to that address.
- R3: An access that opens a row drives ras_o for one cycle with dram_addr_o equal to the row. The later cas_o cycle carries dram_addr_o equal to the column. ras_o and cas_o are never high in the same cycle.
- R4: A read of the row already open issues no row strobe. Its response is visible after the second rising edge, counting the accepting edge as the first.
- R5: A read to a row while no row is open responds after the third edge. A read to a different row while one is open responds after the fourth edge, because one extra cycle closes the old row.
- R6: A write to the open row updates the row buffer, and later reads of that row see it. When the row closes, the buffer is written back, so the value survives a switch to another row or a refresh.
- R7: Each accepted read gives exactly one rsp_valid_o pulse, one cycle long. A write gives no response.
- R8: With no requests, a refresh strobe occurs every REF_CYCLES cycles. A refresh strobe is ras_o high with cas_o low. It drives the refreshed row on dram_addr_o, and the rows go in ascending order, wrapping from 3 to 0.
- R9: Once the refresh deadline expires, req_ready_o stays low until the refresh is done. An open row is closed before the refresh, so the next access to it is a closed-row miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Word address: row in [3:2], column in [1:0] |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata_o | output | 8 | Read data |
| ras_o | output | 1 | Row strobe, used for activate and refresh |
| cas_o | output | 1 | Column strobe |
| dram_addr_o | output | 2 | Multiplexed row/column address |

## Verification
The hardest case to reach from the ports is a refresh deadline that expires while a dirty row is open and requests keep arriving. Only then do the stall, the write-back and the forced close all happen together. The bench first waits for an idle refresh strobe, which fixes the deadline phase. It then writes one cell and streams back-to-back row-hit reads of that cell across the deadline. Finally it checks that the refresh address comes in rotation, that the next read pays the closed-row latency, and that the written value survives.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_REF
  } ctrl_state_e;
endpackage

// File: rtl/dram_cells.sv
module dram_cells #(
  parameter int unsigned NROW  = 4,
  parameter int unsigned ROW_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(NROW)-1:0] rd_row_i,
  output logic [ROW_W-1:0]        rd_data_o,
  input  logic                    wr_en_i,
  input  logic [$clog2(NROW)-1:0] wr_row_i,
  input  logic [ROW_W-1:0]        wr_data_i
);
  logic [ROW_W-1:0] mem_q [NROW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NROW); i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_row_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_row_i];
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int unsigned REF_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic due_o
);
  localparam int unsigned CNT_W = $clog2(REF_CYCLES);
  // the idle period is the count span plus the due cycle plus the refresh cycle
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(REF_CYCLES - 2);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (ack_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign due_o = (cnt_q == LIMIT);

  AST_ACK_ONLY_WHEN_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> due_o); // R8
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
  import pgdram_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RC_BITS    = 2,
  parameter int unsigned REF_CYCLES = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_we_i,
  input  logic [2*RC_BITS-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   rsp_valid_o,
  output logic [DATA_W-1:0]      rsp_rdata_o,
  output logic                   ras_o,
  output logic                   cas_o,
  output logic [RC_BITS-1:0]     dram_addr_o
);
  localparam int unsigned NCOL  = 1 << RC_BITS;
  localparam int unsigned NROW  = NCOL;
  localparam int unsigned ROW_W = NCOL * DATA_W;

  ctrl_state_e state_q, state_d;

  logic                           row_open_q, pend_q;
  logic [RC_BITS-1:0]             open_row_q, row_q, col_q, ref_row_q;
  logic                           we_q;
  logic [DATA_W-1:0]              wdata_q;
  logic [NCOL-1:0][DATA_W-1:0]    buf_q;
  logic                           rsp_valid_q;
  logic [DATA_W-1:0]              rsp_rdata_q;

  logic               ref_due, ref_ack, accept, hit;
  logic [RC_BITS-1:0] req_row, req_col, arr_rd_row, arr_wr_row;
  logic [ROW_W-1:0]   arr_rd_data, arr_wr_data;
  logic               arr_wr_en;

  assign req_row = req_addr_i[2*RC_BITS-1:RC_BITS];
  assign req_col = req_addr_i[RC_BITS-1:0];

  assign req_ready_o = (state_q == ST_IDLE) && !ref_due;
  assign accept      = req_valid_i && req_ready_o;
  assign hit         = row_open_q && (open_row_q == req_row);
  assign ref_ack     = (state_q == ST_REF);

  refresh_timer #(.REF_CYCLES(REF_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (ref_ack),
    .due_o (ref_due)
  );

  // refresh rewrites the row it reads; precharge stores the buffer
  assign arr_rd_row  = (state_q == ST_REF) ? ref_row_q : row_q;
  assign arr_wr_en   = (state_q == ST_PRE) || (state_q == ST_REF);
  assign arr_wr_row  = (state_q == ST_PRE) ? open_row_q : ref_row_q;
  assign arr_wr_data = (state_q == ST_PRE) ? ROW_W'(buf_q) : arr_rd_data;

  dram_cells #(.NROW(NROW), .ROW_W(ROW_W)) u_cells (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_row_i (arr_rd_row),
    .rd_data_o(arr_rd_data),
    .wr_en_i  (arr_wr_en),
    .wr_row_i (arr_wr_row),
    .wr_data_i(arr_wr_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_due)     state_d = row_open_q ? ST_PRE : ST_REF;
        else if (accept) state_d = hit ? ST_COL : (row_open_q ? ST_PRE : ST_ACT);
      end
      ST_PRE:  state_d = pend_q ? ST_ACT : ST_REF;
      ST_ACT:  state_d = ST_COL;
      ST_COL:  state_d = ST_IDLE;
      ST_REF:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      row_open_q  <= 1'b0;
      pend_q      <= 1'b0;
      open_row_q  <= '0;
      row_q       <= '0;
      col_q       <= '0;
      ref_row_q   <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      buf_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= 1'b0;
      if (accept) begin
        pend_q  <= 1'b1;
        we_q    <= req_we_i;
        row_q   <= req_row;
        col_q   <= req_col;
        wdata_q <= req_wdata_i;
      end
      unique case (state_q)
        ST_PRE: row_open_q <= 1'b0;
        ST_ACT: begin
          buf_q      <= arr_rd_data;
          row_open_q <= 1'b1;
          open_row_q <= row_q;
        end
        ST_COL: begin
          pend_q <= 1'b0;
          if (we_q) begin
            buf_q[col_q] <= wdata_q;
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= buf_q[col_q];
          end
        end
        ST_REF:  ref_row_q <= ref_row_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    ras_o       = (state_q == ST_ACT) || (state_q == ST_REF);
    cas_o       = (state_q == ST_COL);
    dram_addr_o = '0;
    if (state_q == ST_REF)      dram_addr_o = ref_row_q;
    else if (state_q == ST_ACT) dram_addr_o = row_q;
    else if (state_q == ST_COL) dram_addr_o = col_q;
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ras_o && cas_o)); // R3
  AST_CAS_NEEDS_OPEN_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_o |-> row_open_q); // R4
  AST_DUE_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_due |-> !req_ready_o); // R9
  AST_REF_ROW_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack |-> !row_open_q); // R9
  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R7
endmodule

// File: tb/pgdram_ctrl_tb_top.sv
module pgdram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REF_CYC    = 40;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic       req_we_i = 1'b0;
  logic [3:0] req_addr_i = '0;
  logic [7:0] req_wdata_i = '0;
  logic       rsp_valid_o;
  logic [7:0] rsp_rdata_o;
  logic       ras_o, cas_o;
  logic [1:0] dram_addr_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pgdram_ctrl #(.DATA_W(8), .RC_BITS(2), .REF_CYCLES(REF_CYC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_we_i(req_we_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .ras_o(ras_o), .cas_o(cas_o), .dram_addr_o(dram_addr_o)
  );

  // strobe monitor
  int         cyc = 0;
  int         ras_n = 0;
  int         ras_time [0:1023];
  logic [1:0] ras_addr [0:1023];
  logic [1:0] last_cas_addr = '0;
  always @(negedge clk_i) begin
    cyc++;
    if (ras_o && !cas_o) begin
      ras_time[ras_n & 1023] = cyc;
      ras_addr[ras_n & 1023] = dram_addr_o;
      ras_n++;
    end
    if (cas_o) last_cas_addr = dram_addr_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int         lat_r;
  logic [7:0] dat_r;

  // starts and ends at a falling edge
  task automatic do_req(input logic we, input logic [3:0] addr, input logic [7:0] wd);
    int guard = 0;
    int extra = 0;
    req_we_i = we; req_addr_i = addr; req_wdata_i = wd; req_valid_i = 1'b1;
    while (!req_ready_o && guard < 200) begin @(negedge clk_i); guard++; end
    @(posedge clk_i); lat_r = 1;
    @(negedge clk_i); req_valid_i = 1'b0;
    if (we) begin
      for (int i = 0; i < 4; i++) begin
        if (rsp_valid_o) extra++;
        @(negedge clk_i);
      end
      chk(extra == 0, "R7 write gives no response", extra, 0);
    end else begin
      while (!rsp_valid_o && lat_r < 20) begin
        @(posedge clk_i); lat_r++; @(negedge clk_i);
      end
      dat_r = rsp_rdata_o;
      @(negedge clk_i);
      chk(!rsp_valid_o, "R7 response is one cycle", rsp_valid_o, 0);
    end
  endtask

  task automatic wait_refresh(output int t, output logic [1:0] a);
    int n = ras_n;
    int guard = 0;
    while (ras_n == n && guard < 200) begin @(negedge clk_i); guard++; end
    t = ras_time[n & 1023];
    a = ras_addr[n & 1023];
  endtask

  function automatic logic [7:0] pat(input logic [3:0] a);
    return 8'h3C ^ {a, ~a};
  endfunction

  task automatic t_reset();
    chk(req_ready_o == 1'b1, "R1 ready after reset", req_ready_o, 1);
    chk(rsp_valid_o == 1'b0, "R1 no response after reset", rsp_valid_o, 0);
    chk(ras_o == 1'b0 && cas_o == 1'b0, "R1 strobes idle", {ras_o, cas_o}, 0);
  endtask

  task automatic t_refresh_rotation();
    int t0, t1;
    logic [1:0] a0, a1;
    wait_refresh(t0, a0);
    for (int k = 0; k < 4; k++) begin
      wait_refresh(t1, a1);
      chk(t1 - t0 == REF_CYC, "R8 refresh spacing", t1 - t0, REF_CYC);
      chk(a1 == a0 + 2'd1, "R8 refresh row order", a1, a0 + 2'd1);
      t0 = t1; a0 = a1;
    end
  endtask

  task automatic t_fill_and_read();
    for (int a = 0; a < 16; a++) do_req(1'b1, 4'(a), pat(4'(a)));
    for (int a = 15; a >= 0; a--) begin
      do_req(1'b0, 4'(a), 8'h00);
      chk(dat_r == pat(4'(a)), "R2 read returns written value", dat_r, pat(4'(a)));
    end
  endtask

  task automatic t_latency();
    int t, n;
    logic [1:0] a;
    wait_refresh(t, a);
    n = ras_n;
    do_req(1'b0, 4'b01_00, 8'h00);
    chk(lat_r == 3, "R5 closed-row miss latency", lat_r, 3);
    chk(ras_addr[n & 1023] == 2'd1, "R3 row on row strobe", ras_addr[n & 1023], 1);
    chk(last_cas_addr == 2'd0, "R3 column on column strobe", last_cas_addr, 0);
    chk(dat_r == pat(4'b01_00), "R2 miss read data", dat_r, pat(4'b01_00));
    n = ras_n;
    do_req(1'b0, 4'b01_10, 8'h00);
    chk(lat_r == 2, "R4 row-hit latency", lat_r, 2);
    chk(ras_n == n, "R4 hit issues no row strobe", ras_n - n, 0);
    chk(last_cas_addr == 2'd2, "R3 hit column address", last_cas_addr, 2);
    chk(dat_r == pat(4'b01_10), "R2 hit read data", dat_r, pat(4'b01_10));
    do_req(1'b0, 4'b11_01, 8'h00);
    chk(lat_r == 4, "R5 open-row conflict latency", lat_r, 4);
    chk(dat_r == pat(4'b11_01), "R2 conflict read data", dat_r, pat(4'b11_01));
  endtask

  task automatic t_writeback();
    int t;
    logic [1:0] a;
    wait_refresh(t, a);
    do_req(1'b1, 4'b10_01, 8'h5A);
    do_req(1'b0, 4'b10_01, 8'h00);
    chk(dat_r == 8'h5A && lat_r == 2, "R6 write hit visible in buffer", dat_r, 8'h5A);
    do_req(1'b0, 4'b00_00, 8'h00);
    do_req(1'b0, 4'b10_01, 8'h00);
    chk(dat_r == 8'h5A, "R6 write-back on row close", dat_r, 8'h5A);
  endtask

  task automatic t_refresh_priority();
    int t, n;
    logic [1:0] a;
    bit seen = 1'b0;
    wait_refresh(t, a);
    do_req(1'b1, 4'b10_11, 8'hA5);
    for (int i = 0; i < 40 && !seen; i++) begin
      n = ras_n;
      do_req(1'b0, 4'b10_11, 8'h00);
      if (ras_n != n) begin
        seen = 1'b1;
        chk(ras_n - n == 2, "R9 refresh then reopen", ras_n - n, 2);
        chk(ras_addr[n & 1023] == a + 2'd1, "R8 refresh row under load", ras_addr[n & 1023], a + 2'd1);
        chk(lat_r == 3, "R9 row closed by refresh", lat_r, 3);
        chk(dat_r == 8'hA5, "R6 dirty row survives refresh", dat_r, 8'hA5);
      end else if (i > 0) begin
        chk(lat_r == 2 && dat_r == 8'hA5, "R4 streaming hit", lat_r, 2);
      end
    end
    chk(seen, "R9 refresh not starved", seen, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_refresh_rotation();
    t_fill_and_read();
    t_latency();
    t_writeback();
    t_refresh_priority();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule